// File: doc/BRIEF.md
# Wake-up exit delay sequencer

This block decides when the processor may start executing again after it leaves a low-power state. The three low-power states are an idle state in which the primary clock keeps running, an idle state running from a secondary or internal clock, and full sleep. When a wake event arrives, the block captures three things: the state being left, the clock source chosen for operation after wake-up, and whether the fast internal oscillator was already running. It then starts the delays that apply. All delays are counted in cycles of a free-running reference tick.

A fixed CPU-prepare delay applies to every exit. A crystal start-up delay applies when a crystal clock has to restart. That delay is extended by a PLL lock period when the PLL is used. A stabilization window applies when the fast internal oscillator has to restart. These delays run concurrently, not one after another. The CPU run enable is raised once the CPU-prepare delay and any start-up delay that gates execution have both ended. Two status flags report a settled crystal clock and a stable fast internal oscillator. The fast oscillator's window does not hold back execution; it only delays its flag. A request to enter a low-power state clears all outputs and aborts any delay in progress.

Top module: `wake_exit_seq`

## Requirements
- R1: During and after reset, cpuRun, xtalReady and fastReady are 0. The block waits in the low-power state until a wake event arrives.
- R2: If no start-up wait applies, cpuRun rises on the clock after the CSD_LEN-th refTick that follows the wake edge. This covers clkSel 2 (external/RC), clkSel 3 (slow internal RC) and codes 5 to 7, which are treated like 2.
- R3: If a start-up wait applies (clkSel 0 or 1, with exitMode not 0), cpuRun rises on the clock after the later of the two counts. The two counts are CSD_LEN and the start-up length, and they run in parallel rather than being added.
- R4: For clkSel 0 (crystal) with exitMode 1 (secondary idle), 2 (sleep) or 3 (treated as sleep), xtalReady rises on the clock after the OST_LEN-th refTick following the wake edge.
- R5: For clkSel 1 (crystal with PLL) with exitMode other than 0, xtalReady and the start-up gate use OST_LEN+PLL_LEN ticks.
- R6: For clkSel 2, 3 or 5 to 7, xtalReady and fastReady stay 0 for the whole time the block is awake.
- R7: For clkSel 4 (fast internal oscillator) with exitMode other than 0 and prevFast 0, cpuRun follows R2. fastReady rises separately, on the clock after the IOB_LEN-th refTick.
- R8: For clkSel 4 with prevFast 1, no stabilization delay applies, and fastReady rises in the same cycle as cpuRun.
- R9: For exitMode 0 (primary-clock idle), no start-up or stabilization wait applies for any clkSel. cpuRun follows R2, and the selected clock's flag rises with cpuRun: xtalReady for clkSel 0 or 1, fastReady for clkSel 4.
- R10: A wake event while the block is awake is ignored. Changes on exitMode, clkSel and prevFast while awake are also ignored, so output timing is unchanged.
- R11: sleepReq clears all three outputs on the next clock and aborts any running delay. It takes priority over a wake event in the same cycle.
- R12: The delay counters advance only on cycles where refTick is 1, so irregular tick patterns stretch the delays by exactly the missing ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Reference tick enable; delays count these |
| wakeEvt | input | 1 | Wake event, sampled while in the low-power state |
| sleepReq | input | 1 | Request to enter a low-power state |
| exitMode | input | 2 | State being left: 0 primary idle, 1 secondary idle, 2/3 sleep |
| clkSel | input | 3 | Clock after wake-up: 0 crystal, 1 crystal+PLL, 2 ext/RC, 3 slow RC, 4 fast internal |
| prevFast | input | 1 | Fast internal oscillator was running before wake-up |
| cpuRun | output | 1 | CPU run enable |
| xtalReady | output | 1 | Crystal clock started and settled |
| fastReady | output | 1 | Fast internal oscillator stable |

## Verification
The hardest situation to reach from the ports is a wake event, together with changed mode and clock inputs, arriving partway through a delay. The block must ignore it, and delays must still stretch correctly when reference ticks go missing. The stimulus injects a second wake with altered inputs a chosen number of cycles after the first, and gates refTick at random. The bench model counts only the ticks actually delivered, so it predicts the exact cycle of every output edge. Aborted delays are reached by raising sleepReq a few cycles into a crystal-with-PLL start-up. The bench then watches long enough to confirm that no stale completion later sets a flag.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    EXIT_PRI   = 2'd0,
    EXIT_SEC   = 2'd1,
    EXIT_SLEEP = 2'd2
  } exit_mode_e;

  typedef enum logic [2:0] {
    SEL_XTAL = 3'd0,
    SEL_XPLL = 3'd1,
    SEL_EXT  = 3'd2,
    SEL_SLOW = 3'd3,
    SEL_FAST = 3'd4
  } clk_sel_e;

  // strobes from control to the delay datapath
  typedef struct packed {
    logic start;
    logic clear;
    logic enSt;
    logic withPll;
    logic enFast;
  } ctl_t;

  // single-cycle completion pulses back to control
  typedef struct packed {
    logic csd;
    logic st;
    logic fast;
  } done_t;

endpackage

// File: rtl/wake_ctr.sv
module wake_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] loadVal,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= loadVal;
      done <= 1'b0;
    end else if (tick && cnt != '0) begin
      cnt  <= cnt - 1'b1;
      done <= (cnt == W'(1));
    end else begin
      done <= 1'b0;
    end
  end

  // counter holds at zero once expired
  p_sat_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !load) |=> (cnt == '0));

  // no movement without a tick
  p_tick_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !load && !clear) |=> $stable(cnt));

  // completion is a single pulse
  p_single_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/wake_dpath.sv
module wake_dpath
  import wake_pkg::*;
#(
  parameter int CSD_LEN = 6,
  parameter int OST_LEN = 20,
  parameter int PLL_LEN = 12,
  parameter int IOB_LEN = 30
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  refTick,
  input  ctl_t  ctl,
  output done_t dn
);

  localparam int ST_MAX = OST_LEN + PLL_LEN;
  localparam int MAX_A  = (CSD_LEN > ST_MAX) ? CSD_LEN : ST_MAX;
  localparam int MAX_L  = (MAX_A > IOB_LEN) ? MAX_A : IOB_LEN;
  localparam int CW     = $clog2(MAX_L + 1);
  localparam int NCTR   = 3;

  logic [CW-1:0]   ldVal [NCTR];
  logic [NCTR-1:0] ld;
  logic [NCTR-1:0] dnV;

  always_comb begin
    ldVal[0] = CW'(CSD_LEN);
    ldVal[1] = ctl.withPll ? CW'(ST_MAX) : CW'(OST_LEN);
    ldVal[2] = CW'(IOB_LEN);
    ld[0]    = ctl.start;
    ld[1]    = ctl.start & ctl.enSt;
    ld[2]    = ctl.start & ctl.enFast;
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    wake_ctr #(.W(CW)) u_ctr (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (refTick),
      .load    (ld[i]),
      .clear   (ctl.clear),
      .loadVal (ldVal[i]),
      .done    (dnV[i])
    );
  end

  assign dn.csd  = dnV[0];
  assign dn.st   = dnV[1];
  assign dn.fast = dnV[2];

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeEvt,
  input  logic       sleepReq,
  input  logic [1:0] exitMode,
  input  logic [2:0] clkSel,
  input  logic       prevFast,
  input  done_t      dn,
  output ctl_t       ctl,
  output logic       cpuRun,
  output logic       xtalReady,
  output logic       fastReady
);

  typedef enum logic {LOWPWR, ACTIVE} st_e;

  st_e        state;
  logic [2:0] selQ;
  logic       needSt, needFast, csdSeen, stSeen;
  logic       startNow, newNeedSt, newNeedFast;
  logic       csdOk, stOk, runNext, selQXtal, stPulse;

  assign stPulse = dn.st;

  always_comb begin
    startNow    = (state == LOWPWR) && wakeEvt && !sleepReq;
    newNeedSt   = (clkSel == SEL_XTAL || clkSel == SEL_XPLL) && (exitMode != EXIT_PRI);
    newNeedFast = (clkSel == SEL_FAST) && (exitMode != EXIT_PRI) && !prevFast;
    ctl.start   = startNow;
    ctl.clear   = sleepReq;
    ctl.enSt    = newNeedSt;
    ctl.withPll = (clkSel == SEL_XPLL);
    ctl.enFast  = newNeedFast;
    selQXtal    = (selQ == SEL_XTAL) || (selQ == SEL_XPLL);
    csdOk       = csdSeen | dn.csd;
    stOk        = !needSt | stSeen | dn.st;
    runNext     = (state == ACTIVE) && csdOk && stOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= LOWPWR;
      selQ      <= SEL_EXT;
      needSt    <= 1'b0;
      needFast  <= 1'b0;
      csdSeen   <= 1'b0;
      stSeen    <= 1'b0;
      cpuRun    <= 1'b0;
      xtalReady <= 1'b0;
      fastReady <= 1'b0;
    end else if (sleepReq) begin
      state     <= LOWPWR;
      csdSeen   <= 1'b0;
      stSeen    <= 1'b0;
      cpuRun    <= 1'b0;
      xtalReady <= 1'b0;
      fastReady <= 1'b0;
    end else if (startNow) begin
      state     <= ACTIVE;
      selQ      <= clkSel;
      needSt    <= newNeedSt;
      needFast  <= newNeedFast;
      csdSeen   <= 1'b0;
      stSeen    <= 1'b0;
      cpuRun    <= 1'b0;
      xtalReady <= 1'b0;
      fastReady <= 1'b0;
    end else if (state == ACTIVE) begin
      csdSeen   <= csdSeen | dn.csd;
      stSeen    <= stSeen | dn.st;
      cpuRun    <= cpuRun | runNext;
      xtalReady <= xtalReady | (needSt ? dn.st : (runNext & selQXtal));
      fastReady <= fastReady | (needFast ? dn.fast : (runNext & (selQ == SEL_FAST)));
    end
  end

  // execution never starts before the prepare delay has completed
  p_run_after_csd_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> csdSeen);

  // execution gated by the start-up wait when one applies
  p_run_after_st_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRun && needSt) |-> stSeen);

  // crystal flag comes from the start-up counter when a wait applies
  p_xtal_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xtalReady) && needSt) |-> $past(stPulse));

  // no status flags for RC-type clocks
  p_no_rc_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ACTIVE && selQ != SEL_XTAL && selQ != SEL_XPLL && selQ != SEL_FAST)
      |-> (!xtalReady && !fastReady));

  // captured context is frozen while awake
  p_ignore_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ACTIVE && !sleepReq) |=> (state == ACTIVE && $stable(selQ) && $stable(needSt)));

  // entering low power clears every output
  p_sleep_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!cpuRun && !xtalReady && !fastReady));

endmodule

// File: rtl/wake_exit_seq.sv
module wake_exit_seq #(
  parameter int CSD_LEN = 6,
  parameter int OST_LEN = 20,
  parameter int PLL_LEN = 12,
  parameter int IOB_LEN = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       wakeEvt,
  input  logic       sleepReq,
  input  logic [1:0] exitMode,
  input  logic [2:0] clkSel,
  input  logic       prevFast,
  output logic       cpuRun,
  output logic       xtalReady,
  output logic       fastReady
);

  wake_pkg::ctl_t  ctl;
  wake_pkg::done_t dn;

  wake_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wakeEvt   (wakeEvt),
    .sleepReq  (sleepReq),
    .exitMode  (exitMode),
    .clkSel    (clkSel),
    .prevFast  (prevFast),
    .dn        (dn),
    .ctl       (ctl),
    .cpuRun    (cpuRun),
    .xtalReady (xtalReady),
    .fastReady (fastReady)
  );

  wake_dpath #(
    .CSD_LEN (CSD_LEN),
    .OST_LEN (OST_LEN),
    .PLL_LEN (PLL_LEN),
    .IOB_LEN (IOB_LEN)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .ctl     (ctl),
    .dn      (dn)
  );

endmodule

// File: tb/tb_wake_exit_seq.sv
module tb_wake_exit_seq;

  localparam int CSD = 6;
  localparam int OST = 20;
  localparam int PLL = 12;
  localparam int IOB = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b1;
  logic wakeEvt = 1'b0;
  logic sleepReq = 1'b0;
  logic prevFast = 1'b0;
  logic [1:0] exitMode = 2'd0;
  logic [2:0] clkSel = 3'd0;
  logic cpuRun, xtalReady, fastReady;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  wake_exit_seq #(.CSD_LEN(CSD), .OST_LEN(OST), .PLL_LEN(PLL), .IOB_LEN(IOB)) dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wakeEvt(wakeEvt), .sleepReq(sleepReq),
    .exitMode(exitMode), .clkSel(clkSel), .prevFast(prevFast),
    .cpuRun(cpuRun), .xtalReady(xtalReady), .fastReady(fastReady)
  );

  task automatic check(string tag, string what, logic got, logic exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit needSt(logic [1:0] m, logic [2:0] s);
    return (s == 3'd0 || s == 3'd1) && m != 2'd0;
  endfunction

  function automatic bit needFast(logic [1:0] m, logic [2:0] s, bit pf);
    return s == 3'd4 && m != 2'd0 && !pf;
  endfunction

  function automatic int stLen(logic [2:0] s);
    return (s == 3'd1) ? OST + PLL : OST;
  endfunction

  function automatic int max3(int a, int b, int c);
    int r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    return r;
  endfunction

  task automatic runWake(logic [1:0] m, logic [2:0] s, bit pf, bit rndTick, int extraAt);
    bit nS = needSt(m, s);
    bit nF = needFast(m, s, pf);
    bit sx = (s <= 3'd1);
    bit sf = (s == 3'd4);
    int tc = 0;
    int csdHit = -1;
    int stHit = -1;
    int fHit = -1;
    bit okR = 1'b1, okX = 1'b1, okF = 1'b1;
    logic eR, eX, eF, gR, gX, gF, xR, xX, xF;
    bit t;
    string tR, tX, tF;
    tR = nS ? "R3" : (nF ? "R7" : (m == 2'd0 ? "R9" : "R2"));
    tX = (s == 3'd0) ? (nS ? "R4" : "R9") : (s == 3'd1) ? (nS ? "R5" : "R9") : "R6";
    tF = nF ? "R7" : (sf ? "R8" : "R6");
    gR = 0; gX = 0; gF = 0; xR = 0; xX = 0; xF = 0;
    @(negedge clk);
    wakeEvt = 1'b1; exitMode = m; clkSel = s; prevFast = pf; refTick = 1'b1;
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      wakeEvt = (k == extraAt);
      if (k == extraAt) begin
        exitMode = ~m; clkSel = 3'(s + 3'd1); prevFast = ~pf;
      end
      t = rndTick ? 1'($urandom % 2) : 1'b1;
      refTick = t;
      @(posedge clk);
      if (t) tc++;
      if (tc == CSD && csdHit < 0) csdHit = k;
      if (nS && tc == stLen(s) && stHit < 0) stHit = k;
      if (nF && tc == IOB && fHit < 0) fHit = k;
      #1;
      eR = csdHit >= 0 && k > csdHit && (!nS || (stHit >= 0 && k > stHit));
      eX = nS ? (stHit >= 0 && k > stHit) : (sx && eR);
      eF = nF ? (fHit >= 0 && k > fHit) : (sf && eR);
      if (okR) begin gR = cpuRun; xR = eR; if (cpuRun !== eR) okR = 1'b0; end
      if (okX) begin gX = xtalReady; xX = eX; if (xtalReady !== eX) okX = 1'b0; end
      if (okF) begin gF = fastReady; xF = eF; if (fastReady !== eF) okF = 1'b0; end
      if (csdHit >= 0 && (!nS || stHit >= 0) && (!nF || fHit >= 0) &&
          k >= max3(csdHit, stHit, fHit) + 3 && k > extraAt) break;
    end
    check(tR, "cpuRun", gR, xR);
    check(tX, "xtalReady", gX, xX);
    check(tF, "fastReady", gF, xF);
    if (extraAt > 0) check("R10", "late wake ignored", okR & okX & okF, 1'b1);
    if (rndTick) check("R12", "gated ticks", okR & okX & okF, 1'b1);
    refTick = 1'b1;
  endtask

  task automatic goSleep(string tag);
    @(negedge clk);
    sleepReq = 1'b1; wakeEvt = 1'b0; refTick = 1'b1;
    @(posedge clk);
    #1;
    check(tag, "outputs cleared", cpuRun | xtalReady | fastReady, 1'b0);
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic watchLow(string tag, int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      seen = seen | cpuRun | xtalReady | fastReady;
    end
    check(tag, "outputs stay low", seen, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "cpuRun in reset", cpuRun, 1'b0);
    check("R1", "xtalReady in reset", xtalReady, 1'b0);
    check("R1", "fastReady in reset", fastReady, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    watchLow("R1", 20);

    // directed clock/mode combinations
    runWake(2'd2, 3'd0, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd1, 3'd1, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd2, 3'd2, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd1, 3'd3, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd2, 3'd4, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd1, 3'd4, 1'b1, 1'b0, 0);  goSleep("R11");
    runWake(2'd0, 3'd4, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd0, 3'd0, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd0, 3'd1, 1'b0, 1'b0, 0);  goSleep("R11");
    runWake(2'd3, 3'd6, 1'b0, 1'b0, 0);  goSleep("R11");
    // R10 wake during a running delay
    runWake(2'd2, 3'd1, 1'b0, 1'b0, 4);  goSleep("R11");
    // R12 irregular ticks
    runWake(2'd2, 3'd1, 1'b0, 1'b1, 0);  goSleep("R11");

    // R11 abort in the middle of a crystal+PLL start-up
    @(negedge clk);
    wakeEvt = 1'b1; exitMode = 2'd2; clkSel = 3'd1; prevFast = 1'b0;
    @(negedge clk);
    wakeEvt = 1'b0;
    repeat (4) @(negedge clk);
    goSleep("R11");
    watchLow("R11", 60);

    // R11 sleep has priority over a simultaneous wake
    @(negedge clk);
    sleepReq = 1'b1; wakeEvt = 1'b1; exitMode = 2'd0; clkSel = 3'd2;
    @(negedge clk);
    sleepReq = 1'b0; wakeEvt = 1'b0;
    watchLow("R11", 30);

    // constrained random runs
    for (int n = 0; n < 40; n++) begin
      logic [1:0] m = 2'($urandom % 4);
      logic [2:0] s = 3'($urandom % 6);
      bit pf = 1'($urandom % 2);
      bit rt = 1'($urandom % 2);
      int ex = (($urandom % 4) == 0) ? 1 + int'($urandom % 10) : 0;
      runWake(m, s, pf, rt, ex);
      goSleep("R11");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule